// File: doc/BRIEF.md
# DMA Request Burst Pacer

This block paces the DMA request line of a peripheral data port. Software or a controlling block sets a burst length in bytes, a bus-width mode and the number of bytes to move, then pulses a start input. The pacer raises its request, holds it while an external DMA master issues a burst of read or write strobes, and drops it for at least one clock when the burst's bytes are used up. It then either re-arms for the next burst or, once the buffer is empty, raises a done flag.

Each strobe moves one bus word: two bytes in 16-bit mode and four bytes in 32-bit mode. Before each burst the current settings are checked. A zero burst, a burst that is not a whole number of bus words, or a remaining byte count that is not a whole number of bursts stops the transfer with an error flag and the request held low. When the burst is exactly one bus word, the request drops after every single access.

Top module: `dreq_burst_pacer`

## Requirements
- R1: After reset, `dreq`, `xfer_done` and `cfg_err` are all 0.
- R2: The burst length `burst_len` is a count of bytes in 13 bits; `wide_mode`=0 selects 16-bit mode and `wide_mode`=1 selects 32-bit mode.
- R3: Each strobe accepted while `dreq` is 1 (either `rd_strobe` or `wr_strobe` high at a clock edge) consumes 2 bytes in 16-bit mode and 4 bytes in 32-bit mode, from both the current burst and the remaining buffer count.
- R4: When `xfer_start` is sampled at clock edge k, `dreq` is 0 after edge k and, for a valid non-empty transfer, 1 after edge k+1.
- R5: `dreq` stays 1 until the strobe that uses the last byte of the burst; it is 0 after the edge that samples that strobe, for exactly one clock, and is 1 again after the following edge when bytes remain.
- R6: With a burst of 2 bytes in 16-bit mode, or of 4 bytes in 32-bit mode, `dreq` drops after every single strobe.
- R7: When the remaining count reaches zero, `dreq` stays 0 and `xfer_done` is 1 one edge after `dreq` fell; a start with a zero byte count sets `xfer_done` one edge after the start is sampled.
- R8: At each burst boundary, a burst of zero, a burst not a multiple of 2 (16-bit mode) or of 4 (32-bit mode), or a non-zero remaining count that is not a multiple of the burst sets `cfg_err` and keeps `dreq` at 0.
- R9: Strobes while `dreq` is 0 are ignored: they consume no bytes and do not change `xfer_done`.
- R10: A change of `burst_len` or `wide_mode` during a burst takes effect only at the next burst boundary.
- R11: `xfer_start` restarts the pacer from any state, clearing `xfer_done` and `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse that loads the byte count and begins a transfer |
| burst_len | input | 13 | Burst length in bytes, sampled at each burst boundary |
| wide_mode | input | 1 | 0: 16-bit bus, 1: 32-bit bus; sampled at each burst boundary |
| buf_bytes | input | 16 | Bytes to move, loaded on `xfer_start` |
| rd_strobe | input | 1 | DMA read access strobe |
| wr_strobe | input | 1 | DMA write access strobe |
| dreq | output | 1 | DMA request, high while a burst is open |
| xfer_done | output | 1 | Buffer fully transferred |
| cfg_err | output | 1 | Burst configuration rejected |

## Verification
The bench uses the default widths: a 13-bit burst field and a 16-bit buffer count. With these, bursts of one to four bus words in both modes and transfers of up to several bursts are all small enough for cycle-exact checking of every request edge, and odd or unaligned burst values and non-multiple byte counts can be mixed in by the random stimulus to reach the rejection paths. Directed cases cover the single-word burst, a mid-burst change of length, strobes in the gap and after completion, and restarts from a busy and an error state.

// File: rtl/dreq_pacer_pkg.sv
package dreq_pacer_pkg;

   // bytes moved by one strobe in each bus mode
   localparam int NARROW_BYTES = 2;
   localparam int WIDE_BYTES   = 4;
   localparam int STEP_W       = 3;

   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_GAP   = 3'd1,
      PS_BURST = 3'd2,
      PS_DONE  = 3'd3,
      PS_ERR   = 3'd4
   } pace_state_e;

   function automatic logic [STEP_W-1:0] step_of(input logic wide);
      return wide ? STEP_W'(WIDE_BYTES) : STEP_W'(NARROW_BYTES);
   endfunction

endpackage

// File: rtl/dreq_cfg_check.sv
module dreq_cfg_check
   import dreq_pacer_pkg::*;
#(
   parameter int BURST_W = 13,
   parameter int BUF_W   = 16
) (
   input  logic [BURST_W-1:0] burst,
   input  logic               wide,
   input  logic [BUF_W-1:0]   remaining,
   output logic               bad
);

   localparam int CW = (BUF_W > BURST_W) ? BUF_W : BURST_W;
   localparam int NMODES = 2;

   initial begin
      assert (BURST_W >= $clog2(WIDE_BYTES) + 1)
         else $error("burst field too narrow for the wide mode");
      assert (CW <= 32) else $error("count width above 32 bits");
   end

   logic [NMODES-1:0] misaligned;

   // one alignment test per bus mode: low address bits of the burst must be 0
   for (genvar m = 0; m < NMODES; m++) begin : g_mode
      localparam int LB = $clog2((m == 0) ? NARROW_BYTES : WIDE_BYTES);
      assign misaligned[m] = |burst[LB-1:0];
   end

   logic          burst_zero;
   logic [CW-1:0] divisor;
   logic [CW-1:0] leftover;

   assign burst_zero = (burst == '0);
   assign divisor    = burst_zero ? CW'(1) : CW'(burst);
   assign leftover   = CW'(remaining) % divisor;

   assign bad = burst_zero || misaligned[wide] || (leftover != '0);

endmodule

// File: rtl/dreq_burst_ctr.sv
module dreq_burst_ctr
   import dreq_pacer_pkg::*;
#(
   parameter int BURST_W = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BURST_W-1:0] load_bytes,
   input  logic               load_wide,
   input  logic               take,
   output logic [STEP_W-1:0]  step,
   output logic               last_word
);

   logic [BURST_W-1:0] left_q;
   logic               wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         wide_q <= 1'b0;
      end else if (load) begin
         left_q <= load_bytes;
         wide_q <= load_wide;
      end else if (take) begin
         left_q <= left_q - BURST_W'(step);
      end
   end

   assign step      = step_of(wide_q);
   assign last_word = (left_q == BURST_W'(step));

endmodule

// File: rtl/dreq_buf_track.sv
module dreq_buf_track
   import dreq_pacer_pkg::*;
#(
   parameter int BUF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BUF_W-1:0]  load_bytes,
   input  logic              take,
   input  logic [STEP_W-1:0] step,
   output logic [BUF_W-1:0]  remaining,
   output logic              empty
);

   logic [BUF_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rem_q <= '0;
      else if (load)   rem_q <= load_bytes;
      else if (take)   rem_q <= rem_q - BUF_W'(step);
   end

   assign remaining = rem_q;
   assign empty     = (rem_q == '0);

endmodule

// File: rtl/dreq_burst_pacer.sv
module dreq_burst_pacer
   import dreq_pacer_pkg::*;
#(
   parameter int BURST_W = 13,
   parameter int BUF_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xfer_start,
   input  logic [BURST_W-1:0] burst_len,
   input  logic               wide_mode,
   input  logic [BUF_W-1:0]   buf_bytes,
   input  logic               rd_strobe,
   input  logic               wr_strobe,
   output logic               dreq,
   output logic               xfer_done,
   output logic               cfg_err
);

   initial begin
      assert (BUF_W >= BURST_W) else $error("buffer count narrower than burst");
   end

   pace_state_e        state_q, state_d;
   logic               strobe;
   logic               take;
   logic               ctr_load;
   logic               cfg_bad;
   logic               last_word;
   logic               rem_empty;
   logic [STEP_W-1:0]  step;
   logic [BUF_W-1:0]   remaining;

   assign strobe   = rd_strobe | wr_strobe;
   assign take     = (state_q == PS_BURST) && strobe && !xfer_start;
   assign ctr_load = (state_q == PS_GAP) && !xfer_start && !rem_empty && !cfg_bad;

   dreq_cfg_check #(.BURST_W(BURST_W), .BUF_W(BUF_W)) u_check (
      .burst     (burst_len),
      .wide      (wide_mode),
      .remaining (remaining),
      .bad       (cfg_bad)
   );

   dreq_burst_ctr #(.BURST_W(BURST_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ctr_load),
      .load_bytes (burst_len),
      .load_wide  (wide_mode),
      .take       (take),
      .step       (step),
      .last_word  (last_word)
   );

   dreq_buf_track #(.BUF_W(BUF_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (xfer_start),
      .load_bytes (buf_bytes),
      .take       (take),
      .step       (step),
      .remaining  (remaining),
      .empty      (rem_empty)
   );

   always_comb begin
      state_d = state_q;
      if (xfer_start) begin
         state_d = PS_GAP;
      end else begin
         unique case (state_q)
            PS_GAP: begin
               if (rem_empty)    state_d = PS_DONE;
               else if (cfg_bad) state_d = PS_ERR;
               else              state_d = PS_BURST;
            end
            PS_BURST: if (strobe && last_word) state_d = PS_GAP;
            default:  state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_IDLE;
      else        state_q <= state_d;
   end

   assign dreq      = (state_q == PS_BURST);
   assign xfer_done = (state_q == PS_DONE);
   assign cfg_err   = (state_q == PS_ERR);

   // R8: a rejected configuration never requests
   a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !dreq);

   // R7: request, done and error are mutually exclusive
   a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dreq, xfer_done, cfg_err}));

   // R5: the strobe on the last word of a burst closes the request
   a_r5_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
      dreq && strobe && last_word && !xfer_start |=> !dreq);

   // R5: after a fall the pacer resolves within one clock
   a_r5_gap_one: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dreq) && !xfer_start |=> (dreq || xfer_done || cfg_err));

   // R9: outside a burst the remaining count does not move
   a_r9_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      !dreq && !xfer_start |=> $stable(remaining));

   // R3: each accepted strobe removes one bus word from the buffer
   a_r3_consume: assert property (@(posedge clk) disable iff (!rst_n)
      dreq && strobe && !xfer_start |=>
         (remaining == $past(remaining) - BUF_W'(NARROW_BYTES)) ||
         (remaining == $past(remaining) - BUF_W'(WIDE_BYTES)));

endmodule

// File: tb/tb_dreq_burst_pacer.sv
`timescale 1ns/1ps
module tb_dreq_burst_pacer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0;
   logic [12:0] burst_len = '0;
   logic        wide_mode = 1'b0;
   logic [15:0] buf_bytes = '0;
   logic        rd_strobe = 1'b0;
   logic        wr_strobe = 1'b0;
   logic        dreq, xfer_done, cfg_err;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   dreq_burst_pacer dut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .burst_len(burst_len),
      .wide_mode(wide_mode), .buf_bytes(buf_bytes), .rd_strobe(rd_strobe),
      .wr_strobe(wr_strobe), .dreq(dreq), .xfer_done(xfer_done), .cfg_err(cfg_err)
   );

   task automatic chk(input int act, input int exp, input string req);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int step_bytes(input bit w);
      return w ? 4 : 2;
   endfunction

   function automatic bit exp_bad(input int b, input bit w, input int n);
      return (b == 0) || (b % step_bytes(w) != 0) || (n % b != 0);
   endfunction

   // drive a start; returns at the negedge after edge k+1
   task automatic start_xfer(input int b, input bit w, input int n);
      @(negedge clk);
      burst_len = 13'(b); wide_mode = w; buf_bytes = 16'(n); xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
      chk(dreq, 0, "R4 low after start");
      @(negedge clk);
   endtask

   // one burst of strobes; entered with dreq expected high
   task automatic run_burst(input int words, input bit last_one, input string req);
      for (int i = 0; i < words; i++) begin
         chk(dreq, 1, {req, " R5 held"});
         if (i % 2 == 0) rd_strobe = 1'b1; else wr_strobe = 1'b1;
         @(negedge clk);
         rd_strobe = 1'b0; wr_strobe = 1'b0;
      end
      chk(dreq, 0, {req, " R5 fall"});
      @(negedge clk);
      if (last_one) begin
         chk(xfer_done, 1, {req, " R7 done"});
         chk(dreq, 0, {req, " R7 quiet"});
      end else begin
         chk(dreq, 1, {req, " R5 rearm"});
      end
   endtask

   initial begin
      int seed_v;
      seed_v = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      chk(dreq, 0, "R1 dreq");
      chk(xfer_done, 0, "R1 done");
      chk(cfg_err, 0, "R1 err");
      rst_n = 1'b1;
      @(negedge clk);
      chk(dreq, 0, "R1 dreq after release");

      // R6: single-word bursts, both modes
      start_xfer(2, 1'b0, 6);
      chk(dreq, 1, "R4 rise");
      for (int j = 0; j < 3; j++) run_burst(1, j == 2, "R6 narrow");
      start_xfer(4, 1'b1, 12);
      for (int j = 0; j < 3; j++) run_burst(1, j == 2, "R6 wide");

      // R2/R3: multi-word bursts, 32-bit mode counts 4 bytes per strobe
      start_xfer(16, 1'b1, 32);
      run_burst(4, 1'b0, "R3 wide");
      run_burst(4, 1'b1, "R3 wide");
      start_xfer(8, 1'b0, 16);
      run_burst(4, 1'b0, "R2 narrow");
      run_burst(4, 1'b1, "R2 narrow");

      // R10: burst changed mid-burst applies at the next boundary
      start_xfer(8, 1'b0, 24);
      chk(dreq, 1, "R10 open");
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      burst_len = 13'd4;
      run_burst(3, 1'b0, "R10 old length");
      for (int j = 0; j < 4; j++) run_burst(2, j == 3, "R10 new length");

      // R9: strobes in the gap and after completion are ignored
      start_xfer(4, 1'b0, 8);
      rd_strobe = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd_strobe = 1'b0;
      chk(dreq, 0, "R9 gap fall");
      wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0;
      chk(dreq, 1, "R9 gap strobe ignored");
      run_burst(2, 1'b1, "R9 bytes kept");
      rd_strobe = 1'b1;
      repeat (3) @(negedge clk);
      rd_strobe = 1'b0;
      chk(xfer_done, 1, "R9 done held");
      chk(dreq, 0, "R9 no request after done");

      // R7: empty transfer
      start_xfer(4, 1'b0, 0);
      chk(xfer_done, 1, "R7 empty done");

      // R8: rejected configurations
      start_xfer(0, 1'b0, 8);
      chk(cfg_err, 1, "R8 zero burst");
      chk(dreq, 0, "R8 zero burst quiet");
      start_xfer(6, 1'b1, 12);
      chk(cfg_err, 1, "R8 unaligned wide");
      start_xfer(3, 1'b0, 6);
      chk(cfg_err, 1, "R8 odd narrow");
      start_xfer(8, 1'b0, 12);
      chk(cfg_err, 1, "R8 not multiple");
      repeat (2) @(negedge clk);
      chk(dreq, 0, "R8 stays quiet");

      // R11: restart from error and from an open burst
      start_xfer(4, 1'b1, 8);
      chk(cfg_err, 0, "R11 err cleared");
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      chk(dreq, 0, "R11 first word");
      start_xfer(8, 1'b0, 8);
      chk(xfer_done, 0, "R11 done clear");
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      start_xfer(2, 1'b0, 4);
      run_burst(1, 1'b0, "R11 restart busy");
      run_burst(1, 1'b1, "R11 restart busy");

      // random mix
      for (int t = 0; t < 40; t++) begin
         bit w;
         int st, words, b, k, n;
         w     = 1'($urandom % 2);
         st    = step_bytes(w);
         words = 1 + int'($urandom % 4);
         b     = words * st;
         if ($urandom % 6 == 0) b = b + 1 + int'($urandom % 2);
         k     = int'($urandom % 4);
         n     = b * k;
         if ($urandom % 6 == 0) n = n + st;
         start_xfer(b, w, n);
         if (n == 0) begin
            chk(xfer_done, 1, "R7 random empty");
         end else if (exp_bad(b, w, n)) begin
            chk(cfg_err, 1, "R8 random reject");
            chk(dreq, 0, "R8 random quiet");
         end else begin
            for (int j = 0; j < n / b; j++)
               run_burst(b / st, j == n / b - 1, "R3 random");
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule